// File: doc/BRIEF.md
# Pin-Selected Clock Configuration Controller

This block sits between a programmable clock source and its output pad. It keeps a small store of configuration fields and uses two select pins to pick one of four profiles. A profile sets which of two multiplier setups is in use, which spread-spectrum code is applied, and which of two stored output-buffer states drives the pad. The block also holds a source multiplexer and an integer divider. The multiplexer picks either the reference clock or the multiplier output. The divider turns the chosen source into the output clock, and the buffer mode of the active profile gates that clock.

All logic runs on a single fast sampling clock. The two clock sources enter as oversampled levels, and the divider counts their rising edges. When configuration mode is enabled, the select pins stop steering the profile and a register-write strobe can change the stored fields. This mode is blocked while the voltage-controlled pull option is strapped on. The output is tri-stated during reset and during a short hold that follows it. After the hold, the profile chosen by the pins is applied. Later changes of profile wait for a low phase of the divided clock.

Top module: `clkcfg_ctrl`

## Requirements
- R1: While reset is asserted, and for the first two clock edges after it is released, `clk_oe` and `clk_out` are 0. On the third edge the profile chosen by `sel_pins` is applied using the reset defaults: ratio 4, reference source, multiplier map 4'b1010, buffer map 4'b1100, buffer state 0 = pass, buffer state 1 = drive-low, spread map 16'hA531.
- R2: `sel_pins` passes through a two-flop synchroniser. While the divided clock is low, a new profile appears on the outputs on the third rising edge after the pins change, and not before.
- R3: While the divided clock is high, a pending profile change is held back. It is applied on the first edge at which the divided clock is low.
- R4: While in configuration mode, `sel_pins` is ignored and the active profile is frozen. After leaving the mode, the pins act again.
- R5: A write is accepted only one edge or more after `cfg_en` = 1 with `pull_en` = 0. With `cfg_en` = 0, or with `pull_en` = 1, `wr_stb` changes nothing.
- R6: The write addresses are: 0 = divide ratio (`wr_data[9:0]`), 1 = source (`wr_data[0]`: 1 = multiplier output, 0 = reference), 2 = multiplier map, 3 = buffer map, 4 = buffer state 0 mode, 5 = buffer state 1 mode, 6 = spread nibbles for profiles 0 and 1, 7 = spread nibbles for profiles 2 and 3. In the maps, bit p belongs to profile p.
- R7: Buffer mode encoding on `buf_mode`: 0 = high impedance (`clk_oe` 0, `clk_out` 0), 1 = drive low (`clk_oe` 1, `clk_out` 0), 2 = pass (`clk_oe` 1, `clk_out` = divided clock). Code 3 behaves as high impedance.
- R8: For a ratio N of 2 or more, the output is high for ceil(N/2) source periods and low for floor(N/2) source periods.
- R9: A ratio of 1 passes the selected source level through with one clock of latency.
- R10: The source field picks which source the divider counts. The selection does not depend on the profile.
- R11: A new ratio written while the divider runs takes effect at the next terminal count, so the running period finishes with the old ratio. A write of ratio 0 is ignored.
- R12: Each profile's spread nibble is {centre, code[2:0]}. Code 0 means no spread and codes 1 to 7 are increasing depths. It drives `ss_centre` and `ss_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_pins | input | 2 | Profile select pins (asynchronous) |
| pull_en | input | 1 | Strap: voltage-controlled pull option on, blocks configuration mode |
| cfg_en | input | 1 | Request configuration mode |
| wr_stb | input | 1 | Register-write strobe |
| wr_addr | input | 3 | Field address |
| wr_data | input | 10 | Write data |
| ref_lvl | input | 1 | Oversampled reference clock level |
| mult_lvl | input | 1 | Oversampled multiplier output level |
| mult_opt | output | 1 | Active multiplier setup index |
| ss_code | output | 3 | Active spread depth code |
| ss_centre | output | 1 | Active spread shape, 1 = centred, 0 = down-side |
| buf_mode | output | 2 | Active output-buffer mode |
| clk_out | output | 1 | Gated divided clock |
| clk_oe | output | 1 | Output drive enable, 0 = high impedance |

## Verification
A profile change on the pins appears three edges later while the divided clock is low. The bench checks the old value after two edges and the new value after three, always sampling at the falling edge. A register write reaches the profile outputs one edge after its strobe. Randomised profile checks therefore wait a fixed 40 cycles, which covers the synchroniser and the longest low-phase wait. Divider results are counted in sampling cycles across a whole output period. Each count is taken only after two full periods have passed since a ratio or source change, except in the reload test. That test deliberately measures the period that is already running when the write lands.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int CC_RATIO_W = 10;
    localparam int CC_DATA_W  = 10;
    localparam int CC_ADDR_W  = 3;
    localparam int CC_NPROF   = 4;
    localparam int CC_SEL_W   = $clog2(CC_NPROF);
    localparam int CC_SS_W    = 4;

    typedef enum logic [1:0] {
        BUF_HIZ  = 2'd0,
        BUF_LOW  = 2'd1,
        BUF_PASS = 2'd2,
        BUF_RSVD = 2'd3
    } buf_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_RUN,
        ST_WAIT_LOW,
        ST_CFG
    } ctl_state_e;

    localparam logic [CC_ADDR_W-1:0] A_RATIO = 3'd0;
    localparam logic [CC_ADDR_W-1:0] A_SRC   = 3'd1;
    localparam logic [CC_ADDR_W-1:0] A_MULT  = 3'd2;
    localparam logic [CC_ADDR_W-1:0] A_BMAP  = 3'd3;
    localparam logic [CC_ADDR_W-1:0] A_BUF0  = 3'd4;
    localparam logic [CC_ADDR_W-1:0] A_BUF1  = 3'd5;
    localparam logic [CC_ADDR_W-1:0] A_SSLO  = 3'd6;
    localparam logic [CC_ADDR_W-1:0] A_SSHI  = 3'd7;

    typedef struct packed {
        logic [CC_RATIO_W-1:0]        ratio;
        logic                         src_mult;
        logic [CC_NPROF-1:0]          mult_map;
        logic [CC_NPROF-1:0]          buf_map;
        logic [1:0]                   buf_mode0;
        logic [1:0]                   buf_mode1;
        logic [CC_NPROF*CC_SS_W-1:0]  ss_map;
    } cfg_t;

endpackage

// File: rtl/cfg_store.sv
module cfg_store
    import clkcfg_pkg::*;
#(
    parameter logic [CC_RATIO_W-1:0]       DEF_RATIO    = 10'd4,
    parameter logic                        DEF_SRC      = 1'b0,
    parameter logic [CC_NPROF-1:0]         DEF_MULT_MAP = 4'b1010,
    parameter logic [CC_NPROF-1:0]         DEF_BUF_MAP  = 4'b1100,
    parameter logic [1:0]                  DEF_BUF0     = 2'd2,
    parameter logic [1:0]                  DEF_BUF1     = 2'd1,
    parameter logic [CC_NPROF*CC_SS_W-1:0] DEF_SS_MAP   = 16'hA531
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CC_ADDR_W-1:0] wr_addr,
    input  logic [CC_DATA_W-1:0] wr_data,
    output cfg_t                 cfg
);

    localparam int HALF_SS = CC_NPROF * CC_SS_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.ratio     <= DEF_RATIO;
            cfg.src_mult  <= DEF_SRC;
            cfg.mult_map  <= DEF_MULT_MAP;
            cfg.buf_map   <= DEF_BUF_MAP;
            cfg.buf_mode0 <= DEF_BUF0;
            cfg.buf_mode1 <= DEF_BUF1;
            cfg.ss_map    <= DEF_SS_MAP;
        end else if (wr_en) begin
            case (wr_addr)
                A_RATIO: if (wr_data[CC_RATIO_W-1:0] != '0) cfg.ratio <= wr_data[CC_RATIO_W-1:0];
                A_SRC:   cfg.src_mult  <= wr_data[0];
                A_MULT:  cfg.mult_map  <= wr_data[CC_NPROF-1:0];
                A_BMAP:  cfg.buf_map   <= wr_data[CC_NPROF-1:0];
                A_BUF0:  cfg.buf_mode0 <= wr_data[1:0];
                A_BUF1:  cfg.buf_mode1 <= wr_data[1:0];
                A_SSLO:  cfg.ss_map[HALF_SS-1:0]         <= wr_data[HALF_SS-1:0];
                default: cfg.ss_map[2*HALF_SS-1:HALF_SS] <= wr_data[HALF_SS-1:0];
            endcase
        end
    end

endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/edge_divider.sv
module edge_divider #(
    parameter int                RATIO_W   = 10,
    parameter logic [RATIO_W-1:0] DEF_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_lvl,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               div_lvl
);

    logic               src_q;
    logic               div_q;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] ratio_act;
    logic [RATIO_W:0]   hi_len;
    logic [RATIO_W:0]   cnt_nxt;
    logic               rise;
    logic               terminal;

    assign rise     = src_lvl & ~src_q;
    assign terminal = (cnt_q == ratio_act - 1'b1);
    assign hi_len   = ({1'b0, ratio_act} + 1'b1) >> 1;
    assign cnt_nxt  = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= 1'b0;
            div_q     <= 1'b0;
            cnt_q     <= '0;
            ratio_act <= DEF_RATIO;
        end else begin
            src_q <= src_lvl;
            if (rise) begin
                if (terminal) begin
                    cnt_q     <= '0;
                    ratio_act <= ratio_in;
                    div_q     <= 1'b1;
                end else begin
                    cnt_q <= cnt_nxt[RATIO_W-1:0];
                    div_q <= (cnt_nxt < hi_len);
                end
            end
        end
    end

    assign div_lvl = (ratio_act == 1) ? src_q : div_q;

endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
    import clkcfg_pkg::*;
#(
    parameter logic [CC_RATIO_W-1:0]       DEF_RATIO    = 10'd4,
    parameter logic                        DEF_SRC      = 1'b0,
    parameter logic [CC_NPROF-1:0]         DEF_MULT_MAP = 4'b1010,
    parameter logic [CC_NPROF-1:0]         DEF_BUF_MAP  = 4'b1100,
    parameter logic [1:0]                  DEF_BUF0     = 2'd2,
    parameter logic [1:0]                  DEF_BUF1     = 2'd1,
    parameter logic [CC_NPROF*CC_SS_W-1:0] DEF_SS_MAP   = 16'hA531,
    parameter int                          SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CC_SEL_W-1:0]  sel_pins,
    input  logic                 pull_en,
    input  logic                 cfg_en,
    input  logic                 wr_stb,
    input  logic [CC_ADDR_W-1:0] wr_addr,
    input  logic [CC_DATA_W-1:0] wr_data,
    input  logic                 ref_lvl,
    input  logic                 mult_lvl,
    output logic                 mult_opt,
    output logic [2:0]           ss_code,
    output logic                 ss_centre,
    output logic [1:0]           buf_mode,
    output logic                 clk_out,
    output logic                 clk_oe
);

    localparam int HOLD_W = $clog2(SYNC_STAGES + 1);
    localparam logic [HOLD_W-1:0] HOLD_LEN = HOLD_W'(SYNC_STAGES);

    ctl_state_e          state_q, state_d;
    logic [CC_SEL_W-1:0] act_sel_q, act_sel_d;
    logic [CC_SEL_W-1:0] sync_sel;
    logic [HOLD_W-1:0]   hold_cnt;
    logic                cfg_act;
    logic                wr_ok;
    logic                div_lvl;
    logic                src_lvl;
    logic [CC_SS_W-1:0]  ss_nib;
    buf_mode_e           mode;
    cfg_t                cfg;

    assign cfg_act = cfg_en & ~pull_en;
    assign wr_ok   = wr_stb & cfg_act & (state_q == ST_CFG);
    assign src_lvl = cfg.src_mult ? mult_lvl : ref_lvl;

    pin_sync #(.W(CC_SEL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sel_pins),
        .q     (sync_sel)
    );

    cfg_store #(
        .DEF_RATIO    (DEF_RATIO),
        .DEF_SRC      (DEF_SRC),
        .DEF_MULT_MAP (DEF_MULT_MAP),
        .DEF_BUF_MAP  (DEF_BUF_MAP),
        .DEF_BUF0     (DEF_BUF0),
        .DEF_BUF1     (DEF_BUF1),
        .DEF_SS_MAP   (DEF_SS_MAP)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    edge_divider #(.RATIO_W(CC_RATIO_W), .DEF_RATIO(DEF_RATIO)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  (src_lvl),
        .ratio_in (cfg.ratio),
        .div_lvl  (div_lvl)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_HOLD;
            act_sel_q <= '0;
            hold_cnt  <= '0;
        end else begin
            state_q   <= state_d;
            act_sel_q <= act_sel_d;
            if (state_q == ST_HOLD && hold_cnt != HOLD_LEN) hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Next state and profile update
    always_comb begin
        state_d   = state_q;
        act_sel_d = act_sel_q;
        unique case (state_q)
            ST_HOLD: begin
                if (hold_cnt == HOLD_LEN) begin
                    act_sel_d = sync_sel;
                    state_d   = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cfg_act) begin
                    state_d = ST_CFG;
                end else if (sync_sel != act_sel_q) begin
                    if (!div_lvl) act_sel_d = sync_sel;
                    else          state_d   = ST_WAIT_LOW;
                end
            end
            ST_WAIT_LOW: begin
                if (cfg_act) begin
                    state_d = ST_CFG;
                end else if (!div_lvl) begin
                    act_sel_d = sync_sel;
                    state_d   = ST_RUN;
                end
            end
            ST_CFG: begin
                if (!cfg_act) state_d = ST_RUN;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        mult_opt  = cfg.mult_map[act_sel_q];
        mode      = buf_mode_e'(cfg.buf_map[act_sel_q] ? cfg.buf_mode1 : cfg.buf_mode0);
        ss_nib    = cfg.ss_map[{act_sel_q, 2'b00} +: CC_SS_W];
        ss_code   = ss_nib[2:0];
        ss_centre = ss_nib[3];
        buf_mode  = mode;
        clk_oe    = 1'b0;
        clk_out   = 1'b0;
        if (state_q != ST_HOLD) begin
            unique case (mode)
                BUF_PASS: begin clk_oe = 1'b1; clk_out = div_lvl; end
                BUF_LOW:  begin clk_oe = 1'b1; clk_out = 1'b0;    end
                default:  begin clk_oe = 1'b0; clk_out = 1'b0;    end
            endcase
        end
    end

endmodule

// File: rtl/clkcfg_ctrl_chk.sv
module clkcfg_ctrl_chk
    import clkcfg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input ctl_state_e           state_q,
    input logic [CC_SEL_W-1:0]  act_sel_q,
    input logic                 div_lvl,
    input logic                 clk_oe,
    input logic                 clk_out,
    input logic [1:0]           buf_mode,
    input logic                 wr_stb,
    input logic                 pull_en,
    input logic [CC_ADDR_W-1:0] wr_addr,
    input logic [CC_DATA_W-1:0] wr_data,
    input cfg_t                 cfg
);

    assert_hold_tri_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (!clk_oe && !clk_out));

    assert_apply_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_sel_q) && $past(state_q) != ST_HOLD) |-> !$past(div_lvl));

    assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CFG) |=> $stable(act_sel_q));

    assert_pull_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && pull_en) |=> $stable(cfg));

    assert_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD && (buf_mode == BUF_HIZ || buf_mode == BUF_RSVD)) |-> (!clk_oe && !clk_out));

    assert_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD && buf_mode == BUF_LOW) |-> (clk_oe && !clk_out));

    assert_zero_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == A_RATIO && wr_data == '0) |=> $stable(cfg.ratio));

endmodule

bind clkcfg_ctrl clkcfg_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .act_sel_q (act_sel_q),
    .div_lvl   (div_lvl),
    .clk_oe    (clk_oe),
    .clk_out   (clk_out),
    .buf_mode  (buf_mode),
    .wr_stb    (wr_stb),
    .pull_en   (pull_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cfg       (cfg)
);

// File: tb/clkcfg_ctrl_test.sv
module clkcfg_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_pins = 2'd0;
    logic       pull_en = 1'b0;
    logic       cfg_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [9:0] wr_data = 10'd0;
    logic       ref_lvl = 1'b0;
    logic       mult_lvl = 1'b0;
    logic       mult_opt, ss_centre, clk_out, clk_oe;
    logic [2:0] ss_code;
    logic [1:0] buf_mode;

    int nchk = 0;
    int nerr = 0;

    // bench model of the stored fields
    logic [3:0]  m_mult = 4'b1010;
    logic [3:0]  m_bmap = 4'b1100;
    logic [1:0]  m_buf [2] = '{2'd2, 2'd1};
    logic [15:0] m_ss   = 16'hA531;
    logic [1:0]  m_pins = 2'd0;

    logic src_on = 1'b0;
    int   mcnt = 0;

    clkcfg_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sel_pins(sel_pins), .pull_en(pull_en),
        .cfg_en(cfg_en), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .ref_lvl(ref_lvl), .mult_lvl(mult_lvl), .mult_opt(mult_opt),
        .ss_code(ss_code), .ss_centre(ss_centre), .buf_mode(buf_mode),
        .clk_out(clk_out), .clk_oe(clk_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // sources: reference period 2 cycles, multiplier period 6 cycles
    always @(negedge clk) begin
        if (src_on) begin
            ref_lvl <= ~ref_lvl;
            if (mcnt == 2) begin mult_lvl <= ~mult_lvl; mcnt <= 0; end
            else mcnt <= mcnt + 1;
        end else begin
            ref_lvl <= 1'b0; mult_lvl <= 1'b0; mcnt <= 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_hi(input int n, input int p);
        return (n == 1) ? p / 2 : ((n + 1) / 2) * p;
    endfunction

    function automatic int exp_lo(input int n, input int p);
        return (n == 1) ? p / 2 : (n / 2) * p;
    endfunction

    task automatic chk_profile(input string tag, input logic [1:0] p);
        logic [1:0] md;
        logic [3:0] nib;
        md  = m_buf[m_bmap[p]];
        nib = m_ss[p*4 +: 4];
        chk({tag, " mult_opt"}, int'(mult_opt), int'(m_mult[p]));
        chk({tag, " buf_mode"}, int'(buf_mode), int'(md));
        chk({tag, " ss_code R12"}, int'(ss_code), int'(nib[2:0]));
        chk({tag, " ss_centre R12"}, int'(ss_centre), int'(nib[3]));
        chk({tag, " clk_oe R7"}, int'(clk_oe), int'(md == 2'd1 || md == 2'd2));
        if (md != 2'd2) chk({tag, " clk_out R7"}, int'(clk_out), 0);
    endtask

    task automatic raw_wr(input logic [2:0] a, input logic [9:0] d);
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [9:0] d);
        raw_wr(a, d);
        case (a)
            3'd2: m_mult = d[3:0];
            3'd3: m_bmap = d[3:0];
            3'd4: m_buf[0] = d[1:0];
            3'd5: m_buf[1] = d[1:0];
            3'd6: m_ss[7:0] = d[7:0];
            3'd7: m_ss[15:8] = d[7:0];
            default: ;
        endcase
    endtask

    task automatic enter_cfg();
        cfg_en = 1'b1; repeat (2) @(negedge clk);
    endtask

    task automatic exit_cfg();
        cfg_en = 1'b0; repeat (2) @(negedge clk);
    endtask

    task automatic set_pins(input logic [1:0] p);
        sel_pins = p; m_pins = p;
        repeat (40) @(negedge clk);
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        for (int g = 0; g < 2000 && clk_out != 1'b0; g++) @(negedge clk);
        for (int g = 0; g < 2000 && clk_out != 1'b1; g++) @(negedge clk);
        for (int g = 0; g < 2000 && clk_out == 1'b1; g++) begin hi++; @(negedge clk); end
        for (int g = 0; g < 2000 && clk_out == 1'b0; g++) begin lo++; @(negedge clk); end
    endtask

    task automatic div_case(input string tag, input int n, input int s);
        int hi, lo;
        cfg_wr(3'd0, 10'(n));
        cfg_wr(3'd1, 10'(s));
        measure(hi, lo); measure(hi, lo); measure(hi, lo);
        chk({tag, " high"}, hi, exp_hi(n, s ? 6 : 2));
        chk({tag, " low"},  lo, exp_lo(n, s ? 6 : 2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int hi, lo;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", int'(clk_oe), 0);
        chk("R1 out in reset", int'(clk_out), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 oe in hold", int'(clk_oe), 0);
        @(posedge clk);
        @(negedge clk);
        chk_profile("R1 default p0", 2'd0);

        // R2: exact synchroniser latency, divided clock low
        sel_pins = 2'd3; m_pins = 2'd3;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 old profile after 2 edges", int'(buf_mode), 2);
        @(posedge clk);
        @(negedge clk);
        chk_profile("R2 new profile after 3 edges", 2'd3);

        src_on = 1'b1;
        set_pins(2'd0);
        chk_profile("R2 back to p0", 2'd0);

        // R4: pins ignored in configuration mode
        enter_cfg();
        sel_pins = 2'd3;
        repeat (20) @(negedge clk);
        chk_profile("R4 frozen in cfg", 2'd0);
        exit_cfg();
        m_pins = 2'd3;
        repeat (40) @(negedge clk);
        chk_profile("R4 pins act after cfg", 2'd3);

        // R5: writes ignored without cfg mode, and with pull option on
        raw_wr(3'd2, 10'(~m_mult));
        repeat (4) @(negedge clk);
        chk("R5 write ignored cfg_en=0", int'(mult_opt), int'(m_mult[m_pins]));
        pull_en = 1'b1; cfg_en = 1'b1;
        repeat (2) @(negedge clk);
        raw_wr(3'd2, 10'(~m_mult));
        repeat (2) @(negedge clk);
        cfg_en = 1'b0; pull_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 write ignored pull_en=1", int'(mult_opt), int'(m_mult[m_pins]));

        // R6 R7 R12: random profiles
        for (int it = 0; it < 30; it++) begin
            enter_cfg();
            cfg_wr(3'd2, 10'($urandom % 16));
            cfg_wr(3'd3, 10'($urandom % 16));
            cfg_wr(3'd4, 10'($urandom % 4));
            cfg_wr(3'd5, 10'($urandom % 4));
            cfg_wr(3'd6, 10'($urandom % 256));
            cfg_wr(3'd7, 10'($urandom % 256));
            exit_cfg();
            set_pins(2'($urandom % 4));
            chk_profile("R6 random profile", m_pins);
        end

        // divider: all profiles pass
        enter_cfg();
        cfg_wr(3'd4, 10'd2);
        cfg_wr(3'd5, 10'd2);
        div_case("R8 odd ratio 7 ref", 7, 0);
        div_case("R8 even ratio 6 ref", 6, 0);
        div_case("R10 ratio 6 mult source", 6, 1);
        div_case("R9 ratio 1 mult pass", 1, 1);
        div_case("R9 ratio 1 ref pass", 1, 0);
        for (int it = 0; it < 8; it++)
            div_case("R8 R10 random ratio", 1 + int'($urandom % 12), int'($urandom % 2));

        // R11: reload at terminal count, zero ignored
        div_case("R11 base ratio 4", 4, 0);
        for (int g = 0; g < 200 && clk_out != 1'b0; g++) @(negedge clk);
        for (int g = 0; g < 200 && clk_out != 1'b1; g++) @(negedge clk);
        raw_wr(3'd0, 10'd10);
        for (int g = 0; g < 200 && clk_out == 1'b1; g++) @(negedge clk);
        lo = 0;
        for (int g = 0; g < 200 && clk_out == 1'b0; g++) begin lo++; @(negedge clk); end
        chk("R11 running period keeps old low", lo, 4);
        measure(hi, lo);
        chk("R11 new ratio high", hi, 10);
        chk("R11 new ratio low", lo, 10);
        raw_wr(3'd0, 10'd0);
        measure(hi, lo); measure(hi, lo);
        chk("R11 zero ratio ignored", hi + lo, 20);

        // R3: change deferred while divided clock is high
        cfg_wr(3'd0, 10'd8);
        cfg_wr(3'd2, 10'b0010);
        exit_cfg();
        set_pins(2'd0);
        for (int g = 0; g < 200 && clk_out != 1'b0; g++) @(negedge clk);
        for (int g = 0; g < 200 && clk_out != 1'b1; g++) @(negedge clk);
        sel_pins = 2'd1; m_pins = 2'd1;
        hi = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (clk_out != 1'b1 || mult_opt != 1'b0) hi++;
        end
        chk("R3 held while high", hi, 0);
        for (int g = 0; g < 200 && clk_out != 1'b0; g++) @(negedge clk);
        @(negedge clk);
        chk("R3 applied in low phase", int'(mult_opt), 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule